// File: doc/BRIEF.md
# Sector Check-Code Syndrome Decoder

The decoder reads two 3-byte Hamming check codes for one 512-byte flash sector. One is the code read back from the spare area. The other is the code recomputed over the data just read. It sorts the outcome into one of four classes:

- no error;
- a single flipped data bit, which can be repaired;
- a fault inside the check code only;
- damage that cannot be repaired.

When a data bit can be repaired, the decoder reports which byte of the sector holds the bad bit and which bit within that byte. A repair path then accepts the byte fetched from that position and returns it with the bad bit flipped back.

Each code is spread over a 32-bit word in two 12-bit halves. The two words are XORed to form a syndrome. The class comes from the population count of the syndrome, which is summed in a registered tree. A sector that was never programmed reads back with all-ones stored code and an all-zero recomputed code. That case is reported as no error. A request strobed on one clock gives its result two clocks later, and a new request may be strobed on every clock.

Top module: `ecc_syndrome_decoder`

## Requirements
- R1: Code byte k sits on bits [8k+7:8k] of `stored_code` and `computed_code`. In the 32-bit word built from a code, byte 0 fills bits 7:0 and byte 1 fills bits 23:16. Byte 2 is split: its low nibble fills bits 11:8 and its high nibble fills bits 27:24. Every other bit is 0. When the two words are equal, `status` is 2'b00 (clean).
- R2: When exactly 12 bits of the syndrome (the XOR of the two words) are set, `status` is 2'b01 (repairable). `err_offset` then equals syndrome bits 27:19, a byte index from 0 to 511.
- R3: In the repairable case, `err_mask` is 1 shifted left by syndrome bits 18:16. `fixed_byte` equals `fix_in` XOR `err_mask` at all times.
- R4: When exactly one syndrome bit is set, `status` is 2'b10 (check-code fault).
- R5: If the syndrome popcount is any value other than 0, 1 or 12, an erased sector still counts as clean and `status` is 2'b00. An erased sector means the stored word is 0x0FFF0FFF (all code bytes 0xFF) and the computed word is 0.
- R6: Any other syndrome popcount other than 0, 1 or 12 gives `status` 2'b11 (uncorrectable).
- R7: A `start` sampled on clock edge n makes `done` high for exactly one cycle after edge n+2. The results for that request appear on the same edge. A new `start` is accepted on every clock. Between `done` pulses, `status`, `err_offset` and `err_mask` hold their values.
- R8: When `status` is not 2'b01, `err_offset` and `err_mask` are zero and `fixed_byte` equals `fix_in`.
- R9: A synchronous active-high `rst` clears `done`, `status`, `err_offset`, `err_mask` and any request in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Samples both codes this cycle |
| stored_code | input | 24 | Check code read from flash |
| computed_code | input | 24 | Check code recomputed over the data |
| fix_in | input | 8 | Byte fetched from the reported offset |
| status | output | 2 | 00 clean, 01 repairable, 10 check-code fault, 11 uncorrectable |
| done | output | 1 | One-cycle pulse marking new results |
| err_offset | output | 9 | Byte index of the bad bit |
| err_mask | output | 8 | One-hot mask of the bad bit |
| fixed_byte | output | 8 | `fix_in` with the bad bit flipped |

## Verification
The bound checker covers the timing and shape of the outputs on every cycle:
- the two-cycle latency and the single-cycle `done` pulse;
- outputs holding between pulses;
- zeroed location fields and the pass-through repair path outside the repairable class;
- a one-hot mask inside it;
- the clean result for equal codes and the check-code-fault result for a one-bit difference.

Some behaviour only the bench scenarios can show. These are the exact byte offset and bit chosen from the location field, including offsets 0 and 511 and bits 0 and 7. They also include the erased-sector exception against a near-erased code that must stay uncorrectable, back-to-back requests, and a reset that lands while a request is in flight.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_REPAIR  = 2'b01,
    ST_CODEERR = 2'b10,
    ST_MULTI   = 2'b11
  } ecc_status_e;
endpackage

// File: rtl/ecc_code_unpack.sv
// Spreads a three-byte check code over a word of four bytes: two halves,
// each holding one full byte plus one nibble of the shared third byte.
module ecc_code_unpack #(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 4 * BYTE_W,
  localparam int HALF_W = 2 * BYTE_W,
  localparam int NIB_W  = BYTE_W / 2
) (
  input  logic [3*BYTE_W-1:0] code,
  output logic [WORD_W-1:0]   word
);
  always_comb begin
    word = '0;
    word[BYTE_W-1:0]                         = code[BYTE_W-1:0];
    word[HALF_W+BYTE_W-1:HALF_W]             = code[2*BYTE_W-1:BYTE_W];
    word[BYTE_W+NIB_W-1:BYTE_W]              = code[2*BYTE_W+NIB_W-1:2*BYTE_W];
    word[HALF_W+BYTE_W+NIB_W-1:HALF_W+BYTE_W] = code[3*BYTE_W-1:2*BYTE_W+NIB_W];
  end
endmodule

// File: rtl/ecc_popcnt_tree.sv
// First level of the population count is registered per leaf; the leaf
// counts are summed combinationally in the following stage.
module ecc_popcnt_tree #(
  parameter int IN_W   = 32,
  parameter int LEAF_W = 4,
  localparam int LEAVES = IN_W / LEAF_W,
  localparam int LCW    = $clog2(LEAF_W + 1),
  localparam int TOT_W  = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IN_W-1:0]  vec,
  output logic [TOT_W-1:0] total
);
  logic [LCW-1:0] leaf_q [LEAVES];

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    logic [LCW-1:0] leaf_d;
    always_comb begin
      leaf_d = '0;
      for (int b = 0; b < LEAF_W; b++)
        leaf_d = leaf_d + LCW'(vec[g*LEAF_W + b]);
    end
    always_ff @(posedge clk) begin
      if (rst)     leaf_q[g] <= '0;
      else if (en) leaf_q[g] <= leaf_d;
    end
  end

  always_comb begin
    total = '0;
    for (int i = 0; i < LEAVES; i++)
      total = total + TOT_W'(leaf_q[i]);
  end
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_syn_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int HALF_W = 16,
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 9,
  localparam int BIT_W = $clog2(BYTE_W),
  localparam int LOC_W = BIT_W + OFS_W,
  localparam int TOT_W = $clog2(WORD_W + 1)
) (
  input  logic [WORD_W-1:0] syn,
  input  logic [TOT_W-1:0]  total,
  input  logic              erased,
  output ecc_status_e       cls,
  output logic [OFS_W-1:0]  offset,
  output logic [BYTE_W-1:0] mask
);
  logic [LOC_W-1:0] loc;
  assign loc = syn[HALF_W+LOC_W-1:HALF_W];

  always_comb begin
    cls    = ST_MULTI;
    offset = '0;
    mask   = '0;
    if (total == '0) begin
      cls = ST_CLEAN;
    end else if (total == TOT_W'(LOC_W)) begin
      cls    = ST_REPAIR;
      offset = loc[LOC_W-1:BIT_W];
      mask   = BYTE_W'(1) << loc[BIT_W-1:0];
    end else if (total == TOT_W'(1)) begin
      cls = ST_CODEERR;
    end else if (erased) begin
      cls = ST_CLEAN;
    end
  end
endmodule

// File: rtl/ecc_syndrome_decoder.sv
module ecc_syndrome_decoder
  import ecc_syn_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int LEAF_W       = 4,
  parameter int OFS_W        = $clog2(SECTOR_BYTES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [3*BYTE_W-1:0] stored_code,
  input  logic [3*BYTE_W-1:0] computed_code,
  input  logic [BYTE_W-1:0]   fix_in,
  output logic [1:0]          status,
  output logic                done,
  output logic [OFS_W-1:0]    err_offset,
  output logic [BYTE_W-1:0]   err_mask,
  output logic [BYTE_W-1:0]   fixed_byte
);
  localparam int WORD_W = 4 * BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int USED_W = BYTE_W + BYTE_W / 2;
  localparam int TOT_W  = $clog2(WORD_W + 1);
  localparam logic [HALF_W-1:0] HALF_ONES = HALF_W'({USED_W{1'b1}});
  localparam logic [WORD_W-1:0] ERASED_WORD = {HALF_ONES, HALF_ONES};

  logic [WORD_W-1:0] stored_w, computed_w, syn_d;

  ecc_code_unpack #(.BYTE_W(BYTE_W)) u_unp_stored (
    .code(stored_code), .word(stored_w));
  ecc_code_unpack #(.BYTE_W(BYTE_W)) u_unp_computed (
    .code(computed_code), .word(computed_w));

  assign syn_d = stored_w ^ computed_w;

  // Stage 1: syndrome, erased flag and leaf counts
  logic              s1_valid, s1_erased;
  logic [WORD_W-1:0] s1_syn;
  logic [TOT_W-1:0]  s1_total;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_erased <= 1'b0;
      s1_syn    <= '0;
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_syn    <= syn_d;
        s1_erased <= (stored_w == ERASED_WORD) && (computed_w == '0);
      end
    end
  end

  ecc_popcnt_tree #(.IN_W(WORD_W), .LEAF_W(LEAF_W)) u_pop (
    .clk(clk), .rst(rst), .en(start), .vec(syn_d), .total(s1_total));

  // Stage 2: classification into registered outputs
  ecc_status_e       cls;
  logic [OFS_W-1:0]  cls_ofs;
  logic [BYTE_W-1:0] cls_mask;

  ecc_syn_classify #(
    .WORD_W(WORD_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W)
  ) u_cls (
    .syn(s1_syn), .total(s1_total), .erased(s1_erased),
    .cls(cls), .offset(cls_ofs), .mask(cls_mask));

  ecc_status_e       status_q;
  logic              done_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [BYTE_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= ST_CLEAN;
      done_q   <= 1'b0;
      ofs_q    <= '0;
      mask_q   <= '0;
    end else begin
      done_q <= s1_valid;
      if (s1_valid) begin
        status_q <= cls;
        ofs_q    <= cls_ofs;
        mask_q   <= cls_mask;
      end
    end
  end

  assign status     = status_q;
  assign done       = done_q;
  assign err_offset = ofs_q;
  assign err_mask   = mask_q;
  assign fixed_byte = fix_in ^ mask_q;
endmodule

// File: rtl/ecc_syndrome_decoder_chk.sv
module ecc_syndrome_decoder_chk #(
  parameter int BYTE_W       = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int LEAF_W       = 4,
  parameter int OFS_W        = $clog2(SECTOR_BYTES)
) (
  input logic                clk,
  input logic                rst,
  input logic                start,
  input logic [3*BYTE_W-1:0] stored_code,
  input logic [3*BYTE_W-1:0] computed_code,
  input logic [BYTE_W-1:0]   fix_in,
  input logic [1:0]          status,
  input logic                done,
  input logic [OFS_W-1:0]    err_offset,
  input logic [BYTE_W-1:0]   err_mask,
  input logic [BYTE_W-1:0]   fixed_byte
);
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 done);

  p_done_origin_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({status, err_offset, err_mask}));

  p_equal_clean_r1: assert property (@(posedge clk) disable iff (rst)
    (start && stored_code == computed_code) |-> ##2 (status == 2'b00));

  p_code_fault_r4: assert property (@(posedge clk) disable iff (rst)
    (start && $countones(stored_code ^ computed_code) == 1) |-> ##2 (status == 2'b10));

  p_mask_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01) |-> ($countones(err_mask) == 1));

  p_zero_fields_r8: assert property (@(posedge clk) disable iff (rst)
    (status != 2'b01) |-> (err_offset == '0 && err_mask == '0));

  p_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (status != 2'b01) |-> (fixed_byte == fix_in));

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!done && status == 2'b00 && err_offset == '0 && err_mask == '0));
endmodule

bind ecc_syndrome_decoder ecc_syndrome_decoder_chk #(
  .BYTE_W(BYTE_W), .SECTOR_BYTES(SECTOR_BYTES), .LEAF_W(LEAF_W), .OFS_W(OFS_W)
) u_chk (.*);

// File: tb/ecc_syndrome_decoder_tb.sv
module ecc_syndrome_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [23:0] stored_code = '0;
  logic [23:0] computed_code = '0;
  logic [7:0]  fix_in = '0;
  logic [1:0]  status;
  logic        done;
  logic [8:0]  err_offset;
  logic [7:0]  err_mask;
  logic [7:0]  fixed_byte;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  ecc_syndrome_decoder u_dut (
    .clk(clk), .rst(rst), .start(start),
    .stored_code(stored_code), .computed_code(computed_code), .fix_in(fix_in),
    .status(status), .done(done), .err_offset(err_offset),
    .err_mask(err_mask), .fixed_byte(fixed_byte));

  function automatic logic [31:0] spread(input logic [23:0] c);
    spread = {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  // Byte differences that produce a given syndrome word (inverse of spread)
  function automatic logic [23:0] diff_of(input logic [31:0] s);
    diff_of = {s[27:24], s[11:8], s[23:16], s[7:0]};
  endfunction

  // Expected {status, offset, mask}
  function automatic logic [18:0] expect_of(input logic [23:0] st, input logic [23:0] cp);
    logic [31:0] syn;
    int          w;
    syn = spread(st) ^ spread(cp);
    w   = $countones(syn);
    if (w == 0)       expect_of = {2'b00, 9'd0, 8'd0};
    else if (w == 12) expect_of = {2'b01, syn[27:19], 8'(8'd1 << syn[18:16])};
    else if (w == 1)  expect_of = {2'b10, 9'd0, 8'd0};
    else if (spread(st) == 32'h0FFF0FFF && spread(cp) == 32'd0)
                      expect_of = {2'b00, 9'd0, 8'd0};
    else              expect_of = {2'b11, 9'd0, 8'd0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] s);
    case (s)
      2'b01:   req_of = "R2";
      2'b10:   req_of = "R4";
      2'b11:   req_of = "R6";
      default: req_of = "R1";
    endcase
  endfunction

  // One request, checked at its result cycle and the cycle after
  task automatic run_vec(input logic [23:0] st, input logic [23:0] cp);
    logic [18:0] e;
    logic [7:0]  b;
    e = expect_of(st, cp);
    @(negedge clk);
    stored_code = st; computed_code = cp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    stored_code = $urandom; computed_code = $urandom;
    @(negedge clk);
    check("R7 done pulse", 32'(done), 32'd1);
    check(req_of(e[18:17]), {13'd0, status, err_offset, err_mask}, {13'd0, e});
    b = 8'($urandom);
    fix_in = b;
    #1;
    check("R3 R8 fixed_byte", 32'(fixed_byte), 32'(b ^ e[7:0]));
    @(negedge clk);
    check("R7 done low after pulse", 32'(done), 32'd0);
    check("R7 results held", {13'd0, status, err_offset, err_mask}, {13'd0, e});
  endtask

  // Build a twelve-bit syndrome whose location field is loc
  function automatic logic [31:0] syn12(input logic [11:0] loc);
    syn12 = {4'h0, loc, 4'h0, ~loc};
  endfunction

  initial begin
    #(20 * 150000);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [23:0] base;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check("R9 reset done", 32'(done), 32'd0);
    check("R9 reset fields", {13'd0, status, err_offset, err_mask}, 32'd0);

    // R1: equal codes
    run_vec(24'h000000, 24'h000000);
    run_vec(24'hA5C3E1, 24'hA5C3E1);
    // R2/R3: location corners
    base = 24'h3C9A51;
    run_vec(base ^ diff_of(syn12(12'hFFF)), base);   // offset 511, bit 7
    run_vec(base ^ diff_of(syn12(12'h000)), base);   // offset 0, bit 0
    run_vec(base ^ diff_of(32'h0FFF0000), base);     // uneven halves, 511 / bit 7
    run_vec(base ^ diff_of(32'h00000FFF), base);     // location field zero
    // R4: single-bit faults in each byte
    run_vec(base ^ 24'h000001, base);
    run_vec(base ^ 24'h800000, base);
    // R5: erased sector
    run_vec(24'hFFFFFF, 24'h000000);
    // R6: near-erased and two-bit cases
    run_vec(24'hFFFFFF, 24'h000001);
    run_vec(base ^ 24'h000003, base);

    // R7: back-to-back requests
    begin
      logic [18:0] e1, e2;
      logic [23:0] s1, s2;
      s1 = base ^ diff_of(syn12(12'h5A3));
      s2 = base ^ 24'h000100;
      e1 = expect_of(s1, base);
      e2 = expect_of(s2, base);
      @(negedge clk); stored_code = s1; computed_code = base; start = 1'b1;
      @(negedge clk); stored_code = s2;
      @(negedge clk); start = 1'b0;
      check("R7 b2b first done", 32'(done), 32'd1);
      check("R7 b2b first R2", {13'd0, status, err_offset, err_mask}, {13'd0, e1});
      @(negedge clk);
      check("R7 b2b second done", 32'(done), 32'd1);
      check("R7 b2b second R4", {13'd0, status, err_offset, err_mask}, {13'd0, e2});
      @(negedge clk);
      check("R7 b2b done drops", 32'(done), 32'd0);
    end

    // R9: reset with a request in flight, after a repairable result
    run_vec(base ^ diff_of(syn12(12'h7C4)), base);
    @(negedge clk); stored_code = 24'h123456; computed_code = 24'h654321; start = 1'b1;
    @(negedge clk); start = 1'b0; rst = 1'b1;
    @(negedge clk);
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R9 flush done", 32'(done), 32'd0);
      check("R9 flush fields", {13'd0, status, err_offset, err_mask}, 32'd0);
    end

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [23:0] cp, st;
      int k;
      cp = 24'($urandom);
      k  = int'($urandom_range(0, 5));
      case (k)
        0: st = cp;
        1: st = cp ^ (24'd1 << $urandom_range(0, 23));
        2: st = cp ^ diff_of(syn12(12'($urandom)));
        3: begin st = 24'hFFFFFF; cp = ($urandom_range(0, 1) == 0) ? 24'd0 : cp; end
        4: st = cp ^ (24'd1 << $urandom_range(0, 11)) ^ (24'd1 << $urandom_range(12, 23));
        default: st = 24'($urandom);
      endcase
      run_vec(st, cp);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule